// File: doc/BRIEF.md
# Asynchronous SRAM timing controller

This block sits between a clocked host and an external 512K x 8 asynchronous static RAM. The host makes one request per transfer, either a read or a write, using a valid/ready handshake. The block turns each request into a sequence of chip-select, write-strobe and output-enable levels on the memory pins. Every phase of that sequence lasts a whole number of system clock cycles. Each count is worked out when the block is built, from the clock period and the nanosecond limits of the memory.

The memory data bus is a shared tri-state bus. It is brought out as three signals: an outgoing word, a drive enable and an incoming word. Something outside the block, at the pad, joins them into the bus. The block drives the bus only while the memory has its outputs shut off. It also waits a turnaround gap after each read so that the memory has released the bus.

A build parameter picks the write method. In the first method the chip select frames the write and the write strobe is pulsed. In the second the write strobe frames the write and the chip select is pulsed. Between operations the chip is deselected, so the memory rests in its low-power standby state.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the three memory strobes are high and the data drive enable is low. `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: After a read is accepted, `sram_ce_no` and `sram_oe_no` are both low, with `sram_we_no` high, for exactly RD_C cycles. RD_C is the largest of ceil(70/T), ceil(35/T) and the read access time in cycles, where T is the clock period in ns. The data bus is sampled on the last of these cycles. That byte is shown on `rsp_rdata_o` with `rsp_valid_o` high for one cycle, RD_C cycles after the accept edge.
- R3: With `CE_WRITE`=0, a write holds `sram_ce_no` low and `sram_oe_no` high for WP_C+2 cycles. Within that window `sram_we_no` is low for exactly WP_C cycles, with one cycle of setup before it and one cycle of hold after it. The write data is driven for all WP_C+2 cycles.
- R4: With `CE_WRITE`=1, a write holds `sram_we_no` low and `sram_oe_no` high for WP_C+2 cycles. Within that window `sram_ce_no` is low for exactly WP_C cycles, with one cycle on each side, and the data is driven for all WP_C+2 cycles.
- R5: While `sram_ce_no` and `sram_we_no` are both low, and on the first cycle after either rises, the address and the write data do not change.
- R6: The block drives the data bus only while `sram_oe_no` is high. It starts to drive no sooner than HZ_C=ceil(25/T) cycles after the last cycle in which `sram_ce_no` and `sram_oe_no` were both low.
- R7: `req_ready_o` falls on the accept edge. After a write it is high again WL_C = max(ceil(70/T), WP_C+2) cycles later. After a read it is high again RD_C+HZ_C cycles later. Two accepts are never less than ceil(70/T) cycles apart.
- R8: WP_C is the largest of ceil(55/T), ceil(60/T)-1 and ceil(25/T)-1. The write strobe therefore lasts at least 55 ns, the address is held for at least 60 ns and the data for at least 25 ns before the strobe that ends the write.
- R9: A request presented while `req_ready_o` is low is ignored. It leaves no trace in the memory contents, which the bench checks by reading them back.
- R10: Whenever `req_ready_o` is high, `sram_ce_no`, `sram_we_no` and `sram_oe_no` are high and the bus is not driven, so the memory is in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller idle, request taken on this edge |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write byte |
| rsp_valid_o | output | 1 | One-cycle read data pulse |
| rsp_rdata_o | output | DATA_W | Read byte |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_dq_o | output | DATA_W | Outgoing bus value |
| sram_dq_oe_o | output | 1 | Bus drive enable |
| sram_dq_i | input | DATA_W | Incoming bus value |
| sram_ce_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_oe_no | output | 1 | Output enable, active low |

## Verification
Some rules are checked by the assertions on every cycle:
- standby while idle;
- the busy drop on accept;
- a single-cycle response pulse;
- a stable address and data across each write and its closing edge;
- no driving with the outputs enabled;
- the turnaround gap;
- the minimum strobe width;
- the shape of the strobes for the selected write method;
- the spacing between accepts.

Other behaviour shows only in the bench's scenarios:
- the exact cycle counts for each strobe and for the busy time;
- the cycle in which read data comes back;
- data coming back correctly through a memory model that returns wrong bytes when read too early;
- the fact that requests made while busy are dropped.

Both write methods run side by side on the same stimulus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_RECOV  = 3'd5
  } sram_st_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // read phase: cycle time, address access and output-enable access
  function automatic int rd_cycles(input int clk_ns, input int rc_ns, input int aa_ns, input int oe_ns);
    return imax(ns2cyc(rc_ns, clk_ns), imax(ns2cyc(aa_ns, clk_ns), ns2cyc(oe_ns, clk_ns)));
  endfunction

  // strobe phase: pulse width, address-to-end less setup cycle, data-to-end less setup cycle
  function automatic int wp_cycles(input int clk_ns, input int wp_ns, input int aw_ns, input int dw_ns);
    return imax(imax(ns2cyc(wp_ns, clk_ns), 1),
                imax(ns2cyc(aw_ns, clk_ns) - 1, ns2cyc(dw_ns, clk_ns) - 1));
  endfunction

  function automatic int hz_cycles(input int clk_ns, input int hz_ns);
    return imax(ns2cyc(hz_ns, clk_ns), 1);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_C   = 14,
  parameter int WP_C   = 11,
  parameter int HZ_C   = 5,
  parameter int WREC_C = 1,
  parameter int CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             tmr_done_i,
  output sram_st_e         state_d_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o
);

  localparam logic [CNT_W-1:0] RD_LEN   = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] WP_LEN   = CNT_W'(WP_C - 1);
  localparam logic [CNT_W-1:0] HZ_LEN   = CNT_W'(HZ_C - 1);
  localparam logic [CNT_W-1:0] WREC_LEN = CNT_W'((WREC_C > 0) ? WREC_C - 1 : 0);

  sram_st_e state_q, state_d;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o & req_valid_i;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_we_i) begin
            state_d = ST_WSETUP;
          end else begin
            state_d    = ST_READ;
            tmr_load_o = 1'b1;
            tmr_len_o  = RD_LEN;
          end
        end
      end
      ST_READ: begin
        if (tmr_done_i) begin
          state_d    = ST_RECOV;
          capture_o  = 1'b1;
          tmr_load_o = 1'b1;
          tmr_len_o  = HZ_LEN;
        end
      end
      ST_WSETUP: begin
        state_d    = ST_WPULSE;
        tmr_load_o = 1'b1;
        tmr_len_o  = WP_LEN;
      end
      ST_WPULSE: begin
        if (tmr_done_i) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        if (WREC_C > 0) begin
          state_d    = ST_RECOV;
          tmr_load_o = 1'b1;
          tmr_len_o  = WREC_LEN;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RECOV: begin
        if (tmr_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter bit CE_WRITE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sram_st_e          state_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rsp_valid_o
);

  localparam pin_ctl_t CTL_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
  localparam pin_ctl_t CTL_RD  = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
  localparam pin_ctl_t CTL_WP  = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};

  // setup/hold framing: the framing strobe stays low, the pulsed one is high
  pin_ctl_t ctl_frame;
  generate
    if (CE_WRITE) begin : g_ce_pulsed
      assign ctl_frame = '{ce_n: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
    end else begin : g_we_pulsed
      assign ctl_frame = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
    end
  endgenerate

  pin_ctl_t ctl_d, ctl_q;

  always_comb begin
    unique case (state_d_i)
      ST_READ:            ctl_d = CTL_RD;
      ST_WSETUP, ST_WHOLD: ctl_d = ctl_frame;
      ST_WPULSE:          ctl_d = CTL_WP;
      default:            ctl_d = CTL_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_OFF;
    else         ctl_q <= ctl_d;
  end

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= capture_i;
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o      = addr_q;
  assign dq_o        = wdata_q;
  assign dq_oe_o     = ctl_q.dq_oe;
  assign ce_n_o      = ctl_q.ce_n;
  assign we_n_o      = ctl_q.we_n;
  assign oe_n_o      = ctl_q.oe_n;
  assign rdata_o     = rdata_q;
  assign rsp_valid_o = rsp_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 5,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_WP_NS  = 55,
  parameter int T_AW_NS  = 60,
  parameter int T_DW_NS  = 25,
  parameter int T_HZ_NS  = 25,
  parameter bit CE_WRITE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no
);

  localparam int CYC_C  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int RD_C   = rd_cycles(CLK_NS, T_RC_NS, T_AA_NS, T_OE_NS);
  localparam int WP_C   = wp_cycles(CLK_NS, T_WP_NS, T_AW_NS, T_DW_NS);
  localparam int HZ_C   = hz_cycles(CLK_NS, T_HZ_NS);
  localparam int WREC_C = (CYC_C > WP_C + 2) ? CYC_C - WP_C - 2 : 0;
  localparam int MAX_C  = imax(imax(RD_C, WP_C), imax(HZ_C, WREC_C));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  sram_st_e         state_d;
  logic             accept, capture, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_len;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  sram_seq_fsm #(
    .RD_C   (RD_C),
    .WP_C   (WP_C),
    .HZ_C   (HZ_C),
    .WREC_C (WREC_C),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .tmr_done_i  (tmr_done),
    .state_d_o   (state_d),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .tmr_load_o  (tmr_load),
    .tmr_len_o   (tmr_len)
  );

  sram_pin_drive #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CE_WRITE (CE_WRITE)
  ) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_d_i   (state_d),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .dq_i        (sram_dq_i),
    .addr_o      (sram_addr_o),
    .dq_o        (sram_dq_o),
    .dq_oe_o     (sram_dq_oe_o),
    .ce_n_o      (sram_ce_no),
    .we_n_o      (sram_we_no),
    .oe_n_o      (sram_oe_no),
    .rdata_o     (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 5,
  parameter int T_RC_NS  = 70,
  parameter int T_WP_NS  = 55,
  parameter int T_AW_NS  = 60,
  parameter int T_DW_NS  = 25,
  parameter int T_HZ_NS  = 25,
  parameter bit CE_WRITE = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no
);

  localparam int CYC_C = ns2cyc(T_RC_NS, CLK_NS);
  localparam int WP_C  = wp_cycles(CLK_NS, T_WP_NS, T_AW_NS, T_DW_NS);
  localparam int HZ_C  = hz_cycles(CLK_NS, T_HZ_NS);
  localparam logic [15:0] SAT = 16'hFFFF;

  logic wr_on, rd_on, accept;
  assign wr_on  = !sram_ce_no && !sram_we_no;
  assign rd_on  = !sram_ce_no && !sram_oe_no;
  assign accept = req_valid_i && req_ready_o;

  logic [15:0] quiet_q, run_q, since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= SAT;
      run_q   <= '0;
      since_q <= SAT;
    end else begin
      quiet_q <= rd_on ? 16'd0 : ((quiet_q == SAT) ? SAT : quiet_q + 16'd1);
      run_q   <= wr_on ? ((run_q == SAT) ? SAT : run_q + 16'd1) : 16'd0;
      since_q <= accept ? 16'd1 : ((since_q == SAT) ? SAT : since_q + 16'd1);
    end
  end

  p_idle_standby_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));

  p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  p_accept_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (since_q >= 16'(CYC_C)));

  p_rsp_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_write_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_on && $past(wr_on)) |-> ($stable(sram_addr_o) && $stable(sram_dq_o) && sram_dq_oe_o));

  p_write_end_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_on) && !wr_on) |-> ($stable(sram_addr_o) && $stable(sram_dq_o) && sram_dq_oe_o));

  p_no_drive_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (quiet_q >= 16'(HZ_C)));

  p_pulse_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_on) && !wr_on) |-> (run_q >= 16'(WP_C)));

  generate
    if (CE_WRITE) begin : g_ce_mode
      p_ce_framing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sram_ce_no && sram_oe_no) |-> !sram_we_no);
    end else begin : g_we_mode
      p_we_framing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sram_we_no |-> (!sram_ce_no && sram_oe_no));
    end
  endgenerate

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CLK_NS   (CLK_NS),
  .T_RC_NS  (T_RC_NS),
  .T_WP_NS  (T_WP_NS),
  .T_AW_NS  (T_AW_NS),
  .T_DW_NS  (T_DW_NS),
  .T_HZ_NS  (T_HZ_NS),
  .CE_WRITE (CE_WRITE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no)
);

// File: tb/sram_model.sv
// Behavioural RAM sampled on the falling clock edge. It checks timing in ns
// from cycle counts and returns inverted bytes when a read is too early.
module sram_model #(
  parameter int T_NS = 5,
  parameter int AW   = 19,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          din_oe,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output int            viol
);

  logic [DW-1:0] mem [int unsigned];
  int addr_cnt = 0, rd_cnt = 0, rel = 1000, dat_cnt = 0, wr_cnt = 0;
  int l_addr_cnt = 0, l_dat_cnt = 0;
  logic l_oe = 1'b0;
  logic [AW-1:0] addr_prev = '0, wr_addr = '0;
  logic [DW-1:0] dat_prev = '0, wr_data = '0;
  logic oe_prev = 1'b0, wr_prev = 1'b0, out_prev = 1'b0;
  logic wr, en_out, en_rd;

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return '0;
  endfunction

  initial begin
    viol = 0;
    dout = '0;
  end

  always @(negedge clk) begin
    wr     = !ce_n && !we_n;
    en_out = !ce_n && !oe_n;
    en_rd  = en_out && we_n;
    addr_cnt = (addr == addr_prev) ? ((addr_cnt < 1000) ? addr_cnt + 1 : addr_cnt) : 1;
    rd_cnt   = en_rd ? ((addr == addr_prev && rd_cnt > 0) ? rd_cnt + 1 : 1) : 0;
    rel      = en_out ? 0 : (out_prev ? 1 : ((rel < 1000) ? rel + 1 : rel));
    dat_cnt  = din_oe ? ((oe_prev && din == dat_prev) ? dat_cnt + 1 : 1) : 0;
    if (din_oe && (en_out || (rel - 1) * T_NS < 25)) begin
      viol++;
      $display("VIOLATION bus contention at %0t", $time);
    end
    if (wr) begin
      if (wr_prev && addr != wr_addr) begin
        viol++;
        $display("VIOLATION address moved during write at %0t", $time);
      end
      wr_cnt     = wr_prev ? wr_cnt + 1 : 1;
      wr_addr    = addr;
      wr_data    = din;
      l_addr_cnt = addr_cnt;
      l_dat_cnt  = dat_cnt;
      l_oe       = din_oe;
    end else if (wr_prev) begin
      if (wr_cnt * T_NS < 55 || l_addr_cnt * T_NS < 60 || !l_oe || l_dat_cnt * T_NS < 25) begin
        viol++;
        $display("VIOLATION write timing pw=%0d as=%0d ds=%0d at %0t", wr_cnt, l_addr_cnt, l_dat_cnt, $time);
      end
      mem[int'(wr_addr)] = wr_data;
    end
    dout = (en_rd && rd_cnt * T_NS >= 70) ? rd(addr) : ~rd(addr);
    addr_prev = addr;
    dat_prev  = din;
    oe_prev   = din_oe;
    wr_prev   = wr;
    out_prev  = en_out;
  end

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

  localparam int T_NS = 5;
  localparam int AW = 19;
  localparam int DW = 8;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_CYC  = cdiv(70, T_NS);
  localparam int E_RD   = mx(E_CYC, mx(cdiv(70, T_NS), cdiv(35, T_NS)));
  localparam int E_HZ   = cdiv(25, T_NS);
  localparam int E_WP   = mx(cdiv(55, T_NS), mx(cdiv(60, T_NS) - 1, cdiv(25, T_NS) - 1));
  localparam int E_WLAT = mx(E_CYC, E_WP + 2);
  localparam int E_RLAT = E_RD + E_HZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic rdy_a, rdy_b, rsp_a, rsp_b, oe_a, oe_b, ce_a, ce_b, we_a, we_b, g_a, g_b;
  logic [DW-1:0] rdat_a, rdat_b, dqo_a, dqo_b, dqi_a, dqi_b;
  logic [AW-1:0] ad_a, ad_b;
  int viol_a, viol_b;

  sram_ctrl #(.CE_WRITE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy_a),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_a), .rsp_rdata_o(rdat_a), .sram_addr_o(ad_a), .sram_dq_o(dqo_a),
    .sram_dq_oe_o(oe_a), .sram_dq_i(dqi_a), .sram_ce_no(ce_a), .sram_we_no(we_a),
    .sram_oe_no(g_a));

  sram_ctrl #(.CE_WRITE(1'b1)) dut_ce (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy_b),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_b), .rsp_rdata_o(rdat_b), .sram_addr_o(ad_b), .sram_dq_o(dqo_b),
    .sram_dq_oe_o(oe_b), .sram_dq_i(dqi_b), .sram_ce_no(ce_b), .sram_we_no(we_b),
    .sram_oe_no(g_b));

  sram_model #(.T_NS(T_NS), .AW(AW), .DW(DW)) m_a (
    .clk(clk), .addr(ad_a), .din(dqo_a), .din_oe(oe_a), .ce_n(ce_a), .we_n(we_a),
    .oe_n(g_a), .dout(dqi_a), .viol(viol_a));

  sram_model #(.T_NS(T_NS), .AW(AW), .DW(DW)) m_b (
    .clk(clk), .addr(ad_b), .din(dqo_b), .din_oe(oe_b), .ce_n(ce_b), .we_n(we_b),
    .oe_n(g_b), .dout(dqi_b), .viol(viol_b));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] sb [int unsigned];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    if (sb.exists(int'(a))) return sb[int'(a)];
    return '0;
  endfunction

  task automatic run_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit junk);
    int i, lat, we_lo_a, ce_lo_a, dq_a, we_lo_b, ce_lo_b, dq_b, rd_a, rd_b, g_lo_w, rsp_at, rsp_n, mism;
    logic [DW-1:0] got_a, got_b, exp_d;
    we_lo_a = 0; ce_lo_a = 0; dq_a = 0; we_lo_b = 0; ce_lo_b = 0; dq_b = 0;
    rd_a = 0; rd_b = 0; g_lo_w = 0; rsp_at = 0; rsp_n = 0; mism = 0;
    got_a = '0; got_b = '0;
    exp_d = expect_rd(a);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!rdy_a) @(negedge clk);
    @(negedge clk);
    if (junk) begin
      req_we = 1'b1; req_addr = a ^ 19'h1; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    i = 1;
    forever begin
      if (rdy_a != rdy_b) mism++;
      if (rdy_a) break;
      if (!we_a) we_lo_a++;
      if (!ce_a) ce_lo_a++;
      if (oe_a)  dq_a++;
      if (!we_b) we_lo_b++;
      if (!ce_b) ce_lo_b++;
      if (oe_b)  dq_b++;
      if (!g_a || !g_b) g_lo_w++;
      if (!ce_a && !g_a && we_a) rd_a++;
      if (!ce_b && !g_b && we_b) rd_b++;
      if (rsp_a) begin
        rsp_n++; rsp_at = i; got_a = rdat_a; got_b = rdat_b;
      end
      @(negedge clk);
      i++;
    end
    req_valid = 1'b0;
    lat = i - 1;
    check(mism == 0, "R7", "ready timing differs between write methods", mism, 0);
    check(ce_a && we_a && g_a && !oe_a && ce_b && we_b && g_b && !oe_b, "R10",
          "pins not in standby when ready", {ce_a, we_a, g_a, oe_a}, 4'b1110);
    if (we) begin
      check(lat == E_WLAT, "R7", "write busy cycles", lat, E_WLAT);
      check(we_lo_a == E_WP, "R3", "strobe-pulsed write low cycles", we_lo_a, E_WP);
      check(ce_lo_a == E_WP + 2, "R3", "select-framed write select cycles", ce_lo_a, E_WP + 2);
      check(dq_a == E_WP + 2, "R3", "drive cycles, strobe-pulsed", dq_a, E_WP + 2);
      check(ce_lo_b == E_WP, "R4", "select-pulsed write select cycles", ce_lo_b, E_WP);
      check(we_lo_b == E_WP + 2, "R4", "strobe-framed write strobe cycles", we_lo_b, E_WP + 2);
      check(dq_b == E_WP + 2, "R4", "drive cycles, select-pulsed", dq_b, E_WP + 2);
      check(g_lo_w == 0, "R6", "output enable low during write", g_lo_w, 0);
      sb[int'(a)] = d;
    end else begin
      check(lat == E_RLAT, "R7", "read busy cycles", lat, E_RLAT);
      check(rd_a == E_RD && rd_b == E_RD, "R2", "read enable cycles", rd_a, E_RD);
      check(rsp_n == 1, "R2", "response pulses", rsp_n, 1);
      check(rsp_at == E_RD + 1, "R2", "response cycle", rsp_at, E_RD + 1);
      check(got_a == exp_d, "R2", "read data, strobe-pulsed", int'(got_a), int'(exp_d));
      check(got_b == exp_d, "R2", "read data, select-pulsed", int'(got_b), int'(exp_d));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ce_a && we_a && g_a && !oe_a && ce_b && we_b && g_b && !oe_b, "R1",
          "pins during reset", {ce_a, we_a, g_a, oe_a}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_a && we_a && g_a && !oe_a && ce_b && we_b && g_b && !oe_b, "R1",
          "pins after reset", {ce_a, we_a, g_a, oe_a}, 4'b1110);
    check(rdy_a && rdy_b, "R1", "ready after reset", int'(rdy_a), 1);
    check(!rsp_a && !rsp_b, "R1", "response after reset", int'(rsp_a), 0);

    for (int a = 0; a < 24; a++)
      run_op(1'b1, AW'(a), DW'(a * 37 + 11), (a == 3) || (a == 9));
    run_op(1'b1, 19'h7FFFF, 8'h5A, 1'b1);
    run_op(1'b1, 19'h40000, 8'hC3, 1'b0);
    run_op(1'b0, 19'h00005, 8'h00, 1'b0);
    run_op(1'b1, 19'h00005, 8'hEE, 1'b0);
    run_op(1'b0, 19'h00005, 8'h00, 1'b1);
    for (int a = 23; a >= 0; a--)
      run_op(1'b0, AW'(a), 8'h00, 1'b0);
    // R9: requests made while busy must have left these untouched
    run_op(1'b0, 19'h00002, 8'h00, 1'b0);
    run_op(1'b0, 19'h00008, 8'h00, 1'b0);
    run_op(1'b0, 19'h7FFFE, 8'h00, 1'b0);
    run_op(1'b0, 19'h00004, 8'h00, 1'b0);
    run_op(1'b0, 19'h7FFFF, 8'h00, 1'b0);
    run_op(1'b0, 19'h40000, 8'h00, 1'b0);
    run_op(1'b0, 19'h12345, 8'h00, 1'b0);
    for (int k = 0; k < 6; k++) begin
      run_op(1'b1, AW'(19'h30000 + k), DW'(8'h90 + k), 1'b0);
      run_op(1'b0, AW'(19'h30000 + k), 8'h00, 1'b0);
    end

    repeat (4) @(negedge clk);
    check(viol_a == 0, "R5", "model timing violations, strobe-pulsed (R6 R8)", viol_a, 0);
    check(viol_b == 0, "R8", "model timing violations, select-pulsed (R5 R6)", viol_b, 0);
    check(!sb.exists(int'(19'h7FFFE)), "R9", "scoreboard kept busy request out", 0, 0);
    report();
    $finish;
  end

endmodule